// File: doc/BRIEF.md
# Twelve-Stage Overlapping Clock Ring

This block is a timing ring that splits each of twelve ring phases into two sub-phases, an early half and a late half, and advances one sub-phase on every enabled clock. The ring state is held in twelve stage triggers. Each trigger stays on for two whole ring phases, so two neighbouring triggers are always on together. A stage turns on when the ring enters the phase just before its own number. It turns off when the stage two places further along turns on.

For every stage the block provides three things. The first is the trigger level. The second is a stage pulse, which is the late sub-phase of the first ring phase the trigger covers. The third is a gated pulse, which is the early sub-phase of the second ring phase the trigger covers. The block also produces a pair of pulse vectors for a consumer some distance away. These carry labels one phase ahead of the local phase, so that a pulse arrives at the far end when that end's own phase has advanced to match.

The enable input freezes the ring in place. While it is low, every pulse output is low. A synchronous reset returns the ring to a fixed starting point, which lies just before phase 0.

Top module: `ovl_clock_ring`

## Requirements
- R1: After reset, `trig_o` is `12'h801` (stages 11 and 0 on) and every pulse vector is zero. The first enabled clock then enters the early half of phase 0, so `stage_gated_o` becomes `12'h001`.
- R2: Each enabled clock advances the ring by exactly one sub-phase, and each ring phase has two sub-phases. A full turn therefore takes 24 enabled clocks, and phase 11 wraps to phase 0.
- R3: Once reset is released, exactly two triggers are on at all times. During ring phase p these are stages p and (p+1) mod 12, so stage n covers phases n-1 and n.
- R4: Stage n turns on at the first sub-phase of phase n-1. It turns off on the same clock that stage (n+2) mod 12 turns on. The trigger vector changes only when the ring crosses from one phase to the next.
- R5: `stage_pulse_o[n]` is high for exactly one clock, during the late sub-phase of phase (n-1) mod 12. This is the first half of stage n's trigger.
- R6: `stage_gated_o[n]` is high for exactly one clock, during the early sub-phase of phase n. This is the second half of stage n's trigger, and the pulse is only ever high while trigger n and trigger n+1 are both on.
- R7: `remote_early_o[k]` and `remote_late_o[k]` carry the early and late sub-phases of local phase (k-1) mod 12. This is a label offset of one, so local phase 0 is reported as remote label 1.
- R8: A clock edge with `en_i` low leaves the triggers and the phase position unchanged. All four pulse vectors are zero after that edge.
- R9: A clock edge with `rst_i` high returns the ring to the state given in R1, even when `en_i` is high.
- R10: No pulse vector ever has more than one bit set. A stage pulse and a gated pulse are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock; each enabled edge is one sub-phase |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the ring and silences pulses |
| trig_o | output | STAGES | Stage trigger levels |
| stage_pulse_o | output | STAGES | Per-stage pulse, late half of the trigger's first phase |
| stage_gated_o | output | STAGES | Per-stage gated pulse, early half of the trigger's second phase |
| remote_early_o | output | STAGES | Early-half pulses labelled one phase ahead |
| remote_late_o | output | STAGES | Late-half pulses labelled one phase ahead |

## Verification
The embedded properties make three assumptions. Reset is asserted on the first clock edge. The ring has at least three stages. The enable input is a plain synchronous level, and no pattern of it is excluded. The stimulus respects these assumptions. It holds reset from time zero and changes the enable and reset inputs only on falling edges. The enable is driven through long runs, periodic gaps, a long stall and a pseudo-random sequence, and one reset is applied while the ring is running with the enable high.

// File: rtl/ovl_ring_pkg.sv
package ovl_ring_pkg;

    // Sub-phase within one ring phase
    typedef enum logic {
        HALF_EARLY = 1'b0,
        HALF_LATE  = 1'b1
    } half_e;

    // Index arithmetic on a ring of size n; offset may be negative
    function automatic int ring_idx(input int i, input int off, input int n);
        return (((i + off) % n) + n) % n;
    endfunction

endpackage

// File: rtl/ovl_ring_sequencer.sv
module ovl_ring_sequencer
    import ovl_ring_pkg::*;
#(
    parameter int STAGES = 12
) (
    input  logic                                   clk_i,
    input  logic                                   rst_i,
    input  logic                                   en_i,
    output logic [((STAGES > 1) ? $clog2(STAGES) : 1)-1:0] ph_q_o,
    output logic [((STAGES > 1) ? $clog2(STAGES) : 1)-1:0] ph_d_o,
    output half_e                                  half_q_o,
    output half_e                                  half_d_o,
    output logic                                   adv_o
);

    localparam int PH_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(STAGES - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        half_e           half;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_i) begin
            if (s_q.half == HALF_LATE) begin
                s_d.half = HALF_EARLY;
                s_d.ph   = (s_q.ph == LAST_PH) ? '0 : s_q.ph + 1'b1;
            end else begin
                s_d.half = HALF_LATE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '{ph: LAST_PH, half: HALF_LATE};
        end else begin
            s_q <= s_d;
        end
    end

    assign ph_q_o   = s_q.ph;
    assign ph_d_o   = s_d.ph;
    assign half_q_o = s_q.half;
    assign half_d_o = s_d.half;
    assign adv_o    = en_i && (s_q.half == HALF_LATE);

    // R2
    ph_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q.ph <= LAST_PH);

    // R2
    early_to_late_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && s_q.half == HALF_EARLY) |=> (s_q.half == HALF_LATE && $stable(s_q.ph)));

    // R8
    hold_position_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(s_q.ph) && $stable(s_q.half)));

endmodule

// File: rtl/ovl_ring_triggers.sv
module ovl_ring_triggers
    import ovl_ring_pkg::*;
#(
    parameter int STAGES = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    output logic [STAGES-1:0] trig_q_o,
    output logic [STAGES-1:0] trig_d_o
);

    // Starting pair: last stage and stage 0, covering the final phase
    localparam logic [STAGES-1:0] START_PAIR =
        {1'b1, {(STAGES-2){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STAGES-1:0] trig;
    } trg_t;

    trg_t t_d, t_q;
    logic [STAGES-1:0] set_vec;
    logic [STAGES-1:0] clr_vec;

    // A stage sets when its two predecessors are the live pair at a
    // phase crossing; it clears when the stage two ahead sets.
    for (genvar n = 0; n < STAGES; n++) begin : g_stage
        localparam int PREV1 = ring_idx(n, -1, STAGES);
        localparam int PREV2 = ring_idx(n, -2, STAGES);
        localparam int NEXT2 = ring_idx(n, 2, STAGES);
        assign set_vec[n] = adv_i && t_q.trig[PREV1] && t_q.trig[PREV2];
        assign clr_vec[n] = set_vec[NEXT2];
    end

    always_comb begin
        t_d      = t_q;
        t_d.trig = set_vec | (t_q.trig & ~clr_vec);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            t_q.trig <= START_PAIR;
        end else begin
            t_q <= t_d;
        end
    end

    assign trig_q_o = t_q.trig;
    assign trig_d_o = t_d.trig;

    // R3
    two_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(t_q.trig) == 2);

    // R4
    hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(t_q.trig));

    // R4
    one_in_one_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_i |=> ($countones(t_q.trig ^ $past(t_q.trig)) == 2));

endmodule

// File: rtl/ovl_ring_pulses.sv
module ovl_ring_pulses
    import ovl_ring_pkg::*;
#(
    parameter int STAGES      = 12,
    parameter int REMOTE_SKEW = 1
) (
    input  logic                                           clk_i,
    input  logic                                           rst_i,
    input  logic                                           en_i,
    input  logic [STAGES-1:0]                              trig_d_i,
    input  half_e                                          half_d_i,
    input  logic [((STAGES > 1) ? $clog2(STAGES) : 1)-1:0] ph_d_i,
    output logic [STAGES-1:0]                              stage_pulse_o,
    output logic [STAGES-1:0]                              stage_gated_o,
    output logic [STAGES-1:0]                              remote_early_o,
    output logic [STAGES-1:0]                              remote_late_o
);

    localparam int PH_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic [STAGES-1:0] gated;
        logic [STAGES-1:0] rem_early;
        logic [STAGES-1:0] rem_late;
    } pls_t;

    pls_t p_d, p_q;
    logic [STAGES-1:0] first_half;
    logic [STAGES-1:0] second_half;
    logic [STAGES-1:0] remote_hit;

    for (genvar n = 0; n < STAGES; n++) begin : g_decode
        localparam int PREV1 = ring_idx(n, -1, STAGES);
        localparam int NEXT1 = ring_idx(n, 1, STAGES);
        localparam logic [PH_W-1:0] SRC_PH =
            PH_W'(ring_idx(n, -REMOTE_SKEW, STAGES));
        // trigger n paired with its predecessor: first phase it covers
        assign first_half[n]  = trig_d_i[n] && trig_d_i[PREV1];
        // trigger n paired with its successor: second phase it covers
        assign second_half[n] = trig_d_i[n] && trig_d_i[NEXT1];
        assign remote_hit[n]  = (ph_d_i == SRC_PH);
    end

    always_comb begin
        p_d = '0;
        if (en_i) begin
            if (half_d_i == HALF_LATE) begin
                p_d.stg      = first_half;
                p_d.rem_late = remote_hit;
            end else begin
                p_d.gated     = second_half;
                p_d.rem_early = remote_hit;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign stage_pulse_o  = p_q.stg;
    assign stage_gated_o  = p_q.gated;
    assign remote_early_o = p_q.rem_early;
    assign remote_late_o  = p_q.rem_late;

    // R10
    stage_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(p_q.stg) && $onehot0(p_q.gated));

    // R10
    remote_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(p_q.rem_early) && $onehot0(p_q.rem_late));

    // R10
    no_half_clash_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !((|p_q.stg) && (|p_q.gated)));

    // R8
    quiet_when_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (p_q == '0));

endmodule

// File: rtl/ovl_clock_ring.sv
module ovl_clock_ring
    import ovl_ring_pkg::*;
#(
    parameter int STAGES      = 12,
    parameter int REMOTE_SKEW = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic [STAGES-1:0] trig_o,
    output logic [STAGES-1:0] stage_pulse_o,
    output logic [STAGES-1:0] stage_gated_o,
    output logic [STAGES-1:0] remote_early_o,
    output logic [STAGES-1:0] remote_late_o
);

    localparam int PH_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic [PH_W-1:0]   ph_q;
    logic [PH_W-1:0]   ph_d;
    half_e             half_q;
    half_e             half_d;
    logic              adv;
    logic [STAGES-1:0] trig_q;
    logic [STAGES-1:0] trig_d;

    ovl_ring_sequencer #(
        .STAGES (STAGES)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .ph_q_o   (ph_q),
        .ph_d_o   (ph_d),
        .half_q_o (half_q),
        .half_d_o (half_d),
        .adv_o    (adv)
    );

    ovl_ring_triggers #(
        .STAGES (STAGES)
    ) u_trg (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .adv_i    (adv),
        .trig_q_o (trig_q),
        .trig_d_o (trig_d)
    );

    ovl_ring_pulses #(
        .STAGES      (STAGES),
        .REMOTE_SKEW (REMOTE_SKEW)
    ) u_pls (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .en_i           (en_i),
        .trig_d_i       (trig_d),
        .half_d_i       (half_d),
        .ph_d_i         (ph_d),
        .stage_pulse_o  (stage_pulse_o),
        .stage_gated_o  (stage_gated_o),
        .remote_early_o (remote_early_o),
        .remote_late_o  (remote_late_o)
    );

    assign trig_o = trig_q;

    // Cross-checks between the phase counter and the self-running triggers
    for (genvar n = 0; n < STAGES; n++) begin : g_cross
        localparam int NEXT1 = ring_idx(n, 1, STAGES);
        localparam int RDST  = ring_idx(n, REMOTE_SKEW, STAGES);

        // R3
        phase_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (ph_q == PH_W'(n)) |-> (trig_q[n] && trig_q[NEXT1]));

        // R6
        gated_inside_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            stage_gated_o[n] |-> (trig_q[n] && trig_q[NEXT1] && half_q == HALF_EARLY));

        // R7
        remote_label_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            remote_early_o[RDST] == stage_gated_o[n]);
    end

endmodule

// File: tb/ovl_clock_ring_test.sv
`timescale 1ns/1ps
module ovl_clock_ring_test;

    localparam int S = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [S-1:0] trig, stg, gat, rem_e, rem_l;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    // behavioural model state
    int m_ph   = S - 1;
    int m_late = 1;
    int m_live = 0;

    ovl_clock_ring uut (
        .clk_i          (clk),
        .rst_i          (rst),
        .en_i           (en),
        .trig_o         (trig),
        .stage_pulse_o  (stg),
        .stage_gated_o  (gat),
        .remote_early_o (rem_e),
        .remote_late_o  (rem_l)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = S - 1; m_late = 1; m_live = 0;
        end else if (en) begin
            if (m_late != 0) begin
                m_late = 0;
                m_ph   = (m_ph + 1) % S;
            end else begin
                m_late = 1;
            end
            m_live = 1;
        end else begin
            m_live = 0;
        end
    end

    function automatic logic [S-1:0] exp_trig();
        logic [S-1:0] v = '0;
        v[m_ph] = 1'b1;
        v[(m_ph + 1) % S] = 1'b1;
        return v;
    endfunction

    function automatic logic [S-1:0] exp_stg();
        logic [S-1:0] v = '0;
        if (m_live != 0 && m_late != 0) v[(m_ph + 1) % S] = 1'b1;
        return v;
    endfunction

    function automatic logic [S-1:0] exp_gat();
        logic [S-1:0] v = '0;
        if (m_live != 0 && m_late == 0) v[m_ph] = 1'b1;
        return v;
    endfunction

    function automatic logic [S-1:0] exp_rem(input int want_late);
        logic [S-1:0] v = '0;
        if (m_live != 0 && m_late == want_late) v[(m_ph + 1) % S] = 1'b1;
        return v;
    endfunction

    task automatic check_vec(input string req, input string what,
                             input logic [S-1:0] act, input logic [S-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check_vec("R3/R4", "trig", trig, exp_trig());
            check_vec("R5", "stage pulse", stg, exp_stg());
            check_vec("R6", "gated pulse", gat, exp_gat());
            check_vec("R7", "remote early", rem_e, exp_rem(0));
            check_vec("R7", "remote late", rem_l, exp_rem(1));
            check_int("R10", "pulse overlap",
                      (($countones(stg) + $countones(gat)) <= 1) ? 1 : 0, 1);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int lfsr = 32'h1ACE;
        logic [S-1:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check_vec("R1", "reset trig", trig, 12'h801);
        check_vec("R1", "reset pulses", stg | gat | rem_e | rem_l, '0);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        check_vec("R1", "held after reset trig", trig, 12'h801);
        en = 1'b1;
        @(negedge clk);
        check_vec("R1", "first gated", gat, 12'h001);
        check_vec("R7", "first remote early", rem_e, 12'h002);
        @(negedge clk);
        check_vec("R5", "stage 1 pulse", stg, 12'h002);
        check_vec("R4", "phase 0 pair", trig, 12'h003);
        // R2: 24 enabled clocks per turn; now at phase 0 late, 23 more to phase 0 early
        repeat (23) @(negedge clk);
        check_vec("R2", "one turn gated", gat, 12'h001);
        repeat (60) @(negedge clk);

        // periodic gaps in enable
        for (int i = 0; i < 150; i++) begin
            en = (i % 3) != 0;
            @(negedge clk);
        end

        // R8: long stall
        en = 1'b1;
        @(negedge clk);
        held = trig;
        en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check_vec("R8", "stall trig", trig, held);
            check_vec("R8", "stall pulses", stg | gat | rem_e | rem_l, '0);
        end

        // R9: reset while running with enable high
        en = 1'b1;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_vec("R9", "mid-run reset trig", trig, 12'h801);
        check_vec("R9", "mid-run reset pulses", stg | gat | rem_e | rem_l, '0);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R9", "restart gated", gat, 12'h001);

        // pseudo-random enable
        for (int i = 0; i < 2000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            en = (lfsr & 3) != 0;
            @(negedge clk);
        end

        finish_run();
    end

endmodule